// File: doc/BRIEF.md
# Serially Loaded Crosspoint Routing Register

This block stores the routing state of a crosspoint switch with 16 outputs and 16 inputs. A controller loads a new routing word one bit at a time through a serial data pin and a serial clock. A separate active-low update strobe then copies that word into a hold stage. The hold stage drives a per-output enable and a 4-bit input select for each output. An active-low chip enable decides whether serial clocks are accepted. The last bit of the shift stage appears on a serial output, so several devices can be chained into one long serial stream.

Everything is sampled on a single system clock. The serial clock is treated as a level that the controller produces in step with that clock, and the block acts on its high-to-low transitions. A digital multiplexer model is built into the block and driven by the hold stage. It lets the routing be observed as data: each output carries the selected input word, or zero when that output is disabled.

Top module: `xpt_cfg_reg`

## Requirements
- R1: The shift stage moves by one bit only at a high-to-low transition of `sclk` seen while `ce_n` is low. With `ce_n` high, serial clocks leave the shift stage unchanged.
- R2: The word is made of one group per output, with output N_OUT-1 configured by the first group shifted in and output 0 by the last.
- R3: Within a group, the first bit shifted is the output enable (1 = enabled). It is followed by the input select, most significant bit first.
- R4: While `upd_n` is high, the hold stage and so `out_en`, `out_sel` and `mux_out` keep their values, even as new bits are shifted in.
- R5: While `upd_n` is low, the hold stage takes the shift-stage contents on every clock, so a word shifted in with `upd_n` held low reaches the outputs without a separate pulse.
- R6: Asserting `rst_n` low clears every enable bit in both the shift stage and the hold stage. The select bits keep their values: `out_sel` is unchanged across reset, and an update right after reset leaves all outputs disabled.
- R7: `mux_out` slice k equals the `mux_in` slice numbered by the select of output k when that output is enabled, and is zero when it is disabled.
- R8: `sdo` is the last stage of the shift stage. After L shifts it presents the first bit shifted in, so a chained device receives the earlier part of a combined stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears enable bits only |
| sclk | input | 1 | Serial clock level; acted on at its falling transition |
| sdi | input | 1 | Serial data in |
| ce_n | input | 1 | Active-low chip enable for serial clocking |
| upd_n | input | 1 | Active-low update; hold stage follows shift stage while low |
| sdo | output | 1 | Serial data out, last shift-stage bit |
| out_en | output | N_OUT | Per-output enable from the hold stage |
| out_sel | output | N_OUT*SW | Per-output input select, output k at bits [k*SW +: SW] |
| mux_in | input | N_IN*DW | Input words of the multiplexer model, input i at [i*DW +: DW] |
| mux_out | output | N_OUT*DW | Output words of the multiplexer model, output k at [k*DW +: DW] |

## Verification
The bench builds the block with its default 16 outputs, 16 inputs and 8-bit data words. That full-size instance covers the complete 80-bit word and the group ordering across all outputs. A second instance with 4 outputs and 4 inputs (2-bit selects, a 12-bit word) is chained from the first one's serial output. With this pair, one 92-bit stream must split correctly between two devices, which exercises the serial output and the parameter-derived group layout at a second size.

// File: rtl/xpt_cfg_reg.sv
module xpt_cfg_reg #(
  parameter int N_OUT = 16,
  parameter int N_IN  = 16,
  parameter int DW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  sdi,
  input  logic                  ce_n,
  input  logic                  upd_n,
  output logic                  sdo,
  output logic [N_OUT-1:0]      out_en,
  output logic [N_OUT*$clog2(N_IN)-1:0] out_sel,
  input  logic [N_IN*DW-1:0]    mux_in,
  output logic [N_OUT*DW-1:0]   mux_out
);
  localparam int SW = $clog2(N_IN);
  localparam int GW = SW + 1;
  localparam int L  = N_OUT * GW;

  logic              sclk_q;
  logic              shift_en;
  logic [L-1:0]      sr_flat;
  logic [L-1:0]      sr_next;
  logic [N_OUT-1:0]  en_sr, en_nx, en_hd;
  logic [N_OUT*SW-1:0] sel_sr, sel_nx, sel_hd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk;

  assign shift_en = sclk_q & ~sclk & ~ce_n;
  assign sr_next  = {sr_flat[L-2:0], sdi};
  assign sdo      = sr_flat[L-1];

  for (genvar o = 0; o < N_OUT; o++) begin : g_grp
    assign sr_flat[o*GW+SW]      = en_sr[o];
    assign sr_flat[o*GW +: SW]   = sel_sr[o*SW +: SW];
    assign en_nx[o]              = sr_next[o*GW+SW];
    assign sel_nx[o*SW +: SW]    = sr_next[o*GW +: SW];
    assign mux_out[o*DW +: DW]   = en_hd[o] ? mux_in[int'(sel_hd[o*SW +: SW])*DW +: DW] : '0;

    always_comb
      if (!en_hd[o]) a_r7_disabled_zero: assert (mux_out[o*DW +: DW] == '0);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_sr <= '0;
      en_hd <= '0;
    end else begin
      if (shift_en) en_sr <= en_nx;
      if (!upd_n)   en_hd <= en_sr;
    end

  always_ff @(posedge clk) begin
    if (shift_en) sel_sr <= sel_nx;
    if (!upd_n)   sel_hd <= sel_sr;
  end

  assign out_en  = en_hd;
  assign out_sel = sel_hd;

  a_r1_no_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || sclk) |=> $stable(sr_flat));
  a_r8_sdo_chain: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sdo == $past(sr_flat[L-2]));
  a_r4_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    upd_n |=> ($stable(out_en) && $stable(out_sel)));
  a_r5_hold_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_n |=> (out_en == $past(en_sr) && out_sel == $past(sel_sr)));
  a_r6_reset_clears: assert property (@(posedge clk)
    !rst_n |-> (out_en == '0 && en_sr == '0));
endmodule

// File: tb/tb_xpt_cfg_reg.sv
module tb_xpt_cfg_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic sclk = 1'b1, sdi = 1'b0, ce_n = 1'b0, upd_n = 1'b1;
  logic sdo, sdo2;
  logic [15:0]  out_en;
  logic [63:0]  out_sel;
  logic [127:0] mux_in;
  logic [127:0] mux_out;
  logic [3:0]   out_en2;
  logic [7:0]   out_sel2;
  logic [31:0]  mux_in2;
  logic [31:0]  mux_out2;

  always #4 clk = ~clk;

  xpt_cfg_reg dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .ce_n(ce_n),
    .upd_n(upd_n), .sdo(sdo), .out_en(out_en), .out_sel(out_sel),
    .mux_in(mux_in), .mux_out(mux_out));

  xpt_cfg_reg #(.N_OUT(4), .N_IN(4), .DW(8)) dut2 (.clk(clk), .rst_n(rst_n),
    .sclk(sclk), .sdi(sdo), .ce_n(ce_n), .upd_n(upd_n), .sdo(sdo2),
    .out_en(out_en2), .out_sel(out_sel2), .mux_in(mux_in2), .mux_out(mux_out2));

  typedef struct {
    int          kind;
    int          idx;
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_en[16], m_sel[16];
  int m2_en[4], m2_sel[4];

  function automatic logic [7:0] inval(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] inval2(int i);
    return 8'(8'h50 + i * 3);
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) mux_in[i*8 +: 8] = inval(i);
    for (int i = 0; i < 4; i++)  mux_in2[i*8 +: 8] = inval2(i);
  end

  task automatic push(int kind, int idx, logic [63:0] exp, string req);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic flush;
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic expect_dut(string req);
    for (int o = 0; o < 16; o++)
      push(0, o, m_en[o] != 0 ? 64'(inval(m_sel[o])) : 64'd0, req);
    flush();
  endtask

  task automatic expect_dut2(string req);
    for (int o = 0; o < 4; o++)
      push(1, o, m2_en[o] != 0 ? 64'(inval2(m2_sel[o])) : 64'd0, req);
    flush();
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = 64'(mux_out[it.idx*8 +: 8]);
        1: act = 64'(mux_out2[it.idx*8 +: 8]);
        2: act = out_sel;
        3: act = 64'(out_en);
        default: act = 64'(sdo);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d idx=%0d actual=%0h expected=%0h",
                 it.req, it.kind, it.idx, act, it.exp);
      end
    end
  end

  task automatic shift_bit(logic b);
    @(negedge clk);
    sdi = b;
    sclk = 1'b0;
    @(negedge clk);
    sclk = 1'b1;
  endtask

  task automatic shift_word(int en[16], int sel[16]);
    for (int o = 15; o >= 0; o--) begin
      shift_bit(en[o] != 0);
      for (int b = 3; b >= 0; b--) shift_bit(sel[o][b]);
    end
  endtask

  task automatic shift_word2(int en[4], int sel[4]);
    for (int o = 3; o >= 0; o--) begin
      shift_bit(en[o] != 0);
      for (int b = 1; b >= 0; b--) shift_bit(sel[o][b]);
    end
  endtask

  task automatic pulse_update;
    @(negedge clk);
    upd_n = 1'b0;
    @(negedge clk);
    upd_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int a_en[16], a_sel[16], t_en[16], t_sel[16];
    int c_en[4], c_sel[4];
    logic [63:0] packed_sel;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    push(3, 0, 64'd0, "R6 reset enables");
    for (int o = 0; o < 16; o++) push(0, o, 64'd0, "R7 reset outputs zero");
    flush();
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R7: distinct selects, some outputs disabled
    for (int o = 0; o < 16; o++) begin
      a_en[o] = (o % 4 == 1) ? 0 : 1;
      a_sel[o] = (o * 5 + 3) % 16;
    end
    shift_word(a_en, a_sel);
    @(negedge clk);
    push(4, 0, 64'(a_en[15]), "R8 sdo shows first bit after full word");
    flush();
    pulse_update();
    m_en = a_en; m_sel = a_sel;
    expect_dut("R2 R3 R7 config A");

    // R4: shift with update high, outputs keep config A
    for (int o = 0; o < 16; o++) begin t_en[o] = 1; t_sel[o] = 15 - o; end
    shift_word(t_en, t_sel);
    @(negedge clk);
    expect_dut("R4 hold keeps while upd_n high");
    pulse_update();
    m_en = t_en; m_sel = t_sel;
    expect_dut("R2 R3 config B after update");

    // R1: chip enable high blocks shifting
    ce_n = 1'b1;
    for (int o = 0; o < 16; o++) begin a_en[o] = 0; a_sel[o] = o; end
    shift_word(a_en, a_sel);
    ce_n = 1'b0;
    pulse_update();
    expect_dut("R1 ce_n high ignores serial clock");

    // R5: update held low, transparent hold
    for (int o = 0; o < 16; o++) begin
      a_en[o] = (o % 3 == 0) ? 0 : 1;
      a_sel[o] = (o * 7 + 2) % 16;
    end
    @(negedge clk);
    upd_n = 1'b0;
    shift_word(a_en, a_sel);
    repeat (2) @(negedge clk);
    m_en = a_en; m_sel = a_sel;
    expect_dut("R5 transparent while upd_n low");
    upd_n = 1'b1;
    @(negedge clk);

    // R6: reset clears enables, selects retained
    for (int o = 0; o < 16; o++) packed_sel[o*4 +: 4] = 4'(a_sel[o]);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push(3, 0, 64'd0, "R6 enables cleared");
    push(2, 0, packed_sel, "R6 selects retained");
    for (int o = 0; o < 16; o++) m_en[o] = 0;
    expect_dut("R6 R7 outputs zero after reset");
    pulse_update();
    push(3, 0, 64'd0, "R6 shift-stage enables cleared");
    push(2, 0, packed_sel, "R6 selects retained after update");
    flush();

    // R8: cascade, far device gets the first part of the stream
    for (int o = 0; o < 4; o++) begin c_en[o] = (o == 2) ? 0 : 1; c_sel[o] = 3 - o; end
    for (int o = 0; o < 16; o++) begin a_en[o] = (o % 2); a_sel[o] = (o * 11 + 5) % 16; end
    shift_word2(c_en, c_sel);
    shift_word(a_en, a_sel);
    pulse_update();
    m_en = a_en; m_sel = a_sel;
    m2_en = c_en; m2_sel = c_sel;
    expect_dut("R8 R2 near device of chain");
    expect_dut2("R8 far device of chain");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule